// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block turns a stream of stereo sample pairs into a serial audio data line. It supports five framings: standard I2S, left-justified, right-justified, and the two PCM short-sync variants. One position counter, running on the bit clock, drives every framing. Samples arrive on a valid/ready port with one holding slot. A pair moves into the active registers at the start of each frame. If no pair is waiting at that point, the previous pair is sent again.

As a clock master, the block divides its system clock to make the bit clock and the frame clock. As a slave, it samples both clocks from its input pins with the system clock and follows them. Configuration is a set of static inputs that are registered on every cycle. The following settings are available:

- bit-clock rate (32 or 64 bit clocks per frame)
- launch edge
- frame-clock polarity
- word length
- framing mode
- one-bit start delay

Combinations that cannot be framed raise an error output, and the data line is held low while that output is high.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is held, the block uses its defaults: slave role, 64 bit clocks per frame, 24-bit words, standard framing with delay, all other settings zero. So cfg_err, clk_oe, sd_o and underrun are 0 and in_ready is 1. The configuration inputs take effect from the first clock edge after reset.
- R2: With cfg_master=1, clk_oe is 1 and bclk_o toggles every CLK_DIV system clock cycles. A frame lasts 64 bit clocks when cfg_rate32=0 and 32 bit clocks when cfg_rate32=1. With cfg_master=0, clk_oe, bclk_o and fclk_o are all 0.
- R3: With cfg_edge=0, sd_o and fclk_o change only where the bit clock falls, so data is valid on the rising edge. With cfg_edge=1, they change only where it rises.
- R4: In modes 0 and 1 the frame splits into two equal halves, and the left word is always in the first half. Frame clock equals cfg_pol during the left half and the inverse during the right half. With cfg_pol=0, low means left.
- R5: cfg_wlen selects the word length: 0 gives 32 bits, 1 gives 24, 2 gives 20 and 3 gives 16. A word is taken from the least significant bits of in_left/in_right and sent most significant bit first.
- R6: Mode 0 is standard framing. With cfg_nodelay=0, a word starts one bit clock after its half begins (I2S). With cfg_nodelay=1, it starts at the first bit of its half (left-justified). Bits after the word are 0.
- R7: Mode 1 is right-justified. The word's last bit sits in the last bit of its half, and the bits before the word are 0. cfg_nodelay has no effect.
- R8: Mode 2 is PCM framing. fclk_o is high for the single bit clock at frame position 0, whatever cfg_pol is set to. The left word and then the right word are sent back to back, starting at position 1 (cfg_nodelay=0) or position 0 (cfg_nodelay=1). The remaining bits are 0.
- R9: cfg_err is 1 for any of these illegal combinations: mode 3; 32 or 24 bits at 32 clocks per frame; right-justified at 32 clocks per frame; right-justified with 32 bits; PCM with 20 bits at 32 clocks per frame. While cfg_err is 1, sd_o stays 0.
- R10: One pair can wait in the holding slot, and in_ready is 1 exactly when that slot is empty. A waiting pair becomes the active pair at the next frame start. The frame start is the launch edge where the position reaches the start delay.
- R11: If the slot is empty at a frame start, the active pair repeats. underrun is then 1 for exactly one system clock cycle, the cycle in which that frame begins.
- R12: With cfg_master=0, a change on bclk_i/fclk_i takes effect at the third rising system clock edge after it. The position returns to 0 at the launch edge where the frame clock enters its start level: the left level for modes 0 and 1, and high for mode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = drive both clocks, 0 = follow input clocks |
| cfg_rate32 | input | 1 | 1 = 32 bit clocks per frame, 0 = 64 |
| cfg_edge | input | 1 | 0 = data valid on rising bit-clock edge, 1 = falling |
| cfg_wlen | input | 2 | Word length code |
| cfg_mode | input | 2 | 0 standard, 1 right-justified, 2 PCM, 3 illegal |
| cfg_nodelay | input | 1 | 1 = no one-bit start delay |
| cfg_pol | input | 1 | Frame-clock level for the left channel |
| in_valid | input | 1 | Sample pair offered |
| in_ready | output | 1 | Holding slot empty |
| in_left | input | 32 | Left sample, right-aligned |
| in_right | input | 32 | Right sample, right-aligned |
| bclk_i | input | 1 | Bit clock in slave role |
| fclk_i | input | 1 | Frame clock in slave role |
| bclk_o | output | 1 | Bit clock in master role |
| fclk_o | output | 1 | Frame clock in master role |
| clk_oe | output | 1 | Clock pins driven by this block |
| sd_o | output | 1 | Serial data |
| cfg_err | output | 1 | Illegal configuration |
| underrun | output | 1 | Pair repeated at this frame start |

## Verification
The bench checks 32-bit words with the one-bit delay, where the last right bit wraps into position 0 of the next frame. A design that swapped pairs at the frame-clock edge would corrupt that bit. It also checks right-justified words with the delay bit set, which a careless design would shift by one. It runs PCM at both rates, where a design using half-frame slots would misplace the right word. The remaining cases are underrun after a limited number of pairs, each illegal combination, and slave framing that must resynchronise to an incoming frame clock. Here a design would repeat the wrong pair, miss the one-cycle pulse, leak data or stay one bit off.

// File: rtl/audio_ser_tx.sv
module audio_ser_tx #(
  parameter int CLK_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_master,
  input  logic        cfg_rate32,
  input  logic        cfg_edge,
  input  logic [1:0]  cfg_wlen,
  input  logic [1:0]  cfg_mode,
  input  logic        cfg_nodelay,
  input  logic        cfg_pol,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_left,
  input  logic [31:0] in_right,
  input  logic        bclk_i,
  input  logic        fclk_i,
  output logic        bclk_o,
  output logic        fclk_o,
  output logic        clk_oe,
  output logic        sd_o,
  output logic        cfg_err,
  output logic        underrun
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [1:0] M_RJ  = 2'd1;
  localparam logic [1:0] M_PCM = 2'd2;

  logic       master_q, rate32_q, edge_q, nodelay_q, pol_q;
  logic [1:0] wlen_q, mode_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      master_q  <= 1'b0;
      rate32_q  <= 1'b0;
      edge_q    <= 1'b0;
      nodelay_q <= 1'b0;
      pol_q     <= 1'b0;
      wlen_q    <= 2'd1;
      mode_q    <= 2'd0;
    end else begin
      master_q  <= cfg_master;
      rate32_q  <= cfg_rate32;
      edge_q    <= cfg_edge;
      nodelay_q <= cfg_nodelay;
      pol_q     <= cfg_pol;
      wlen_q    <= cfg_wlen;
      mode_q    <= cfg_mode;
    end

  logic       is_rj, is_pcm;
  logic [6:0] frame_len, half_len, wbits, dly;

  assign is_rj     = (mode_q == M_RJ);
  assign is_pcm    = (mode_q == M_PCM);
  assign frame_len = rate32_q ? 7'd32 : 7'd64;
  assign half_len  = rate32_q ? 7'd16 : 7'd32;
  assign dly       = (is_rj || nodelay_q) ? 7'd0 : 7'd1;

  always_comb
    case (wlen_q)
      2'd0:    wbits = 7'd32;
      2'd1:    wbits = 7'd24;
      2'd2:    wbits = 7'd20;
      default: wbits = 7'd16;
    endcase

  assign cfg_err = (mode_q == 2'd3)
                || (rate32_q && !wlen_q[1])
                || (is_rj && (rate32_q || wlen_q == 2'd0))
                || (is_pcm && rate32_q && wlen_q == 2'd2);

  logic run_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;

  logic [DIV_W-1:0] div_q;
  logic             bclk_q, div_hit;

  assign div_hit = (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (run_q && master_q) begin
      if (div_hit) begin
        div_q  <= '0;
        bclk_q <= ~bclk_q;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end

  logic [1:0] bsync_q, fsync_q;
  logic       bslv_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bsync_q <= 2'b00;
      fsync_q <= 2'b00;
      bslv_q  <= 1'b0;
    end else begin
      bsync_q <= {bsync_q[0], bclk_i};
      fsync_q <= {fsync_q[0], fclk_i};
      bslv_q  <= bsync_q[1];
    end

  logic mst_tick, slv_tick, tick;
  assign mst_tick = run_q && master_q && div_hit && (~bclk_q == edge_q);
  assign slv_tick = run_q && !master_q && (bsync_q[1] != bslv_q) && (bsync_q[1] == edge_q);
  assign tick     = mst_tick || slv_tick;

  logic [5:0] pos_q, pos_inc, pos_nxt;
  logic       was_start_q, at_start, realign, load;

  assign pos_inc  = ({1'b0, pos_q} >= frame_len - 7'd1) ? 6'd0 : pos_q + 6'd1;
  assign at_start = (fsync_q[1] == (is_pcm ? 1'b1 : pol_q));
  assign realign  = !master_q && at_start && !was_start_q;
  assign pos_nxt  = realign ? 6'd0 : pos_inc;
  assign load     = tick && (pos_nxt == dly[5:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos_q       <= 6'h3F;
      was_start_q <= 1'b1;
    end else if (tick) begin
      pos_q       <= pos_nxt;
      was_start_q <= at_start;
    end

  logic [31:0] act_l, act_r, hold_l, hold_r;
  logic        hold_v;

  assign in_ready = !hold_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_l    <= '0;
      act_r    <= '0;
      hold_l   <= '0;
      hold_r   <= '0;
      hold_v   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      underrun <= load && !hold_v;
      if (load && hold_v) begin
        act_l <= hold_l;
        act_r <= hold_r;
      end
      if (in_valid && !hold_v) begin
        hold_v <= 1'b1;
        hold_l <= in_left;
        hold_r <= in_right;
      end else if (load) begin
        hold_v <= 1'b0;
      end
    end

  logic [6:0] q, slot_pos, wstart;
  logic [4:0] idx;
  logic       chan, in_frame, bit_v;

  always_comb begin
    q        = {1'b0, pos_q} + frame_len - dly;
    if (q >= frame_len) q = q - frame_len;
    chan     = 1'b0;
    slot_pos = q;
    wstart   = 7'd0;
    in_frame = ({1'b0, pos_q} < frame_len);
    idx      = 5'd0;
    bit_v    = 1'b0;
    if (is_pcm) begin
      chan     = (q >= wbits);
      slot_pos = chan ? q - wbits : q;
      in_frame = in_frame && (q < {wbits[5:0], 1'b0});
    end else begin
      chan     = (q >= half_len);
      slot_pos = chan ? q - half_len : q;
      wstart   = is_rj ? half_len - wbits : 7'd0;
    end
    if (in_frame && slot_pos >= wstart && slot_pos < wstart + wbits) begin
      idx   = 5'(wbits - 7'd1 - (slot_pos - wstart));
      bit_v = chan ? act_r[idx] : act_l[idx];
    end
  end

  assign sd_o   = bit_v && !cfg_err;
  assign clk_oe = master_q;
  assign bclk_o = master_q && bclk_q;
  assign fclk_o = master_q && (is_pcm ? (pos_q == 6'd0)
                                      : (({1'b0, pos_q} >= half_len) ^ pol_q));
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic edge_cfg,
  input logic clk_oe,
  input logic bclk_o,
  input logic fclk_o,
  input logic sd_o,
  input logic cfg_err,
  input logic underrun,
  input logic in_valid,
  input logic in_ready
);
  AST_SLAVE_PINS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe |-> (!bclk_o && !fclk_o)); // R2

  AST_DATA_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe && $past(clk_oe) && !$stable(sd_o)) |-> (!$stable(bclk_o) && bclk_o == edge_cfg)); // R3

  AST_FRAME_ON_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe && $past(clk_oe) && !$stable(fclk_o)) |-> (!$stable(bclk_o) && bclk_o == edge_cfg)); // R4

  AST_ERR_MUTES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !sd_o); // R9

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready); // R10

  AST_UNDERRUN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun); // R11
endmodule

bind audio_ser_tx audio_ser_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .edge_cfg (edge_q),
  .clk_oe   (clk_oe),
  .bclk_o   (bclk_o),
  .fclk_o   (fclk_o),
  .sd_o     (sd_o),
  .cfg_err  (cfg_err),
  .underrun (underrun),
  .in_valid (in_valid),
  .in_ready (in_ready)
);

// File: tb/audio_ser_tx_tb.sv
module audio_ser_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int SDIV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic c_master = 0, c_rate32 = 0, c_edge = 0, c_nodelay = 0, c_pol = 0;
  logic [1:0] c_wlen = 0, c_mode = 0;
  logic in_valid = 0;
  logic [31:0] in_left = 0, in_right = 0;
  logic bclk_i = 0, fclk_i = 0;
  logic in_ready, bclk_o, fclk_o, clk_oe, sd_o, cfg_err, underrun;

  audio_ser_tx #(.CLK_DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(c_master), .cfg_rate32(c_rate32),
    .cfg_edge(c_edge), .cfg_wlen(c_wlen), .cfg_mode(c_mode), .cfg_nodelay(c_nodelay),
    .cfg_pol(c_pol), .in_valid(in_valid), .in_ready(in_ready), .in_left(in_left),
    .in_right(in_right), .bclk_i(bclk_i), .fclk_i(fclk_i), .bclk_o(bclk_o),
    .fclk_o(fclk_o), .clk_oe(clk_oe), .sd_o(sd_o), .cfg_err(cfg_err), .underrun(underrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model state
  bit mon_on = 0, feed_on = 0, slv_on = 0;
  int feed_left = 0;
  bit acc_pend = 0;
  bit [31:0] acc_l, acc_r;
  bit [2:0] bh = 0, fh = 0;
  int m_pos;
  bit m_was, m_prevb, m_lastbo, m_seen;
  int m_bcnt;
  bit [31:0] m_l, m_r;
  bit [31:0] ql[$], qr[$];

  function automatic int n_len();  return c_rate32 ? 32 : 64; endfunction
  function automatic int w_len();
    case (c_wlen) 2'd0: return 32; 2'd1: return 24; 2'd2: return 20; default: return 16; endcase
  endfunction
  function automatic int d_len(); return (c_mode == 2'd1 || c_nodelay) ? 0 : 1; endfunction
  function automatic bit exp_err();
    return c_mode == 2'd3 || (c_rate32 && c_wlen <= 2'd1) ||
           (c_mode == 2'd1 && (c_rate32 || c_wlen == 2'd0)) ||
           (c_mode == 2'd2 && c_rate32 && c_wlen == 2'd2);
  endfunction

  function automatic bit exp_bit(int pos);
    int n = n_len(), w = w_len(), h, base, off, qq;
    bit [31:0] word;
    h = n / 2;
    if (pos >= n) return 0;
    qq = (pos - d_len() + n) % n;
    if (c_mode == 2'd2) begin
      if (qq < w) return m_l[w-1-qq];
      if (qq < 2*w) return m_r[2*w-1-qq];
      return 0;
    end
    base = (qq < h) ? 0 : h;
    word = (qq < h) ? m_l : m_r;
    off  = qq - base;
    if (c_mode == 2'd1) off = off - (h - w);
    if (off < 0 || off >= w) return 0;
    return word[w-1-off];
  endfunction

  function automatic bit exp_fclk();
    if (!c_master) return 0;
    if (c_mode == 2'd2) return m_pos == 0;
    return (m_pos >= n_len()/2) ^ c_pol;
  endfunction

  task automatic model_reset();
    m_pos = 63; m_was = 1; m_prevb = 0; m_lastbo = 0; m_seen = 0; m_bcnt = 0;
    m_l = 0; m_r = 0; ql.delete(); qr.delete(); acc_pend = 0;
  endtask

  task automatic step();
    bit b_now, tick, eu, st;
    int nxt;
    eu = 0;
    b_now = c_master ? bclk_o : bh[2];
    tick = (b_now != m_prevb) && (b_now == c_edge);
    m_prevb = b_now;
    if (c_master) begin
      m_bcnt++;
      if (bclk_o != m_lastbo) begin
        if (m_seen) chk("R2", "bit clock half period", m_bcnt, DIV);
        m_seen = 1; m_bcnt = 0; m_lastbo = bclk_o;
      end
    end
    if (tick) begin
      nxt = (m_pos >= n_len() - 1) ? 0 : m_pos + 1;
      if (!c_master) begin
        st = (fh[2] == ((c_mode == 2'd2) ? 1'b1 : c_pol));
        if (st && !m_was) nxt = 0;
        m_was = st;
      end
      m_pos = nxt;
      if (m_pos == d_len()) begin
        if (ql.size() > 0) begin m_l = ql.pop_front(); m_r = qr.pop_front(); end
        else eu = 1;
      end
    end
    if (acc_pend) begin ql.push_back(acc_l); qr.push_back(acc_r); end
    chk(tag, "sd_o", sd_o, exp_err() ? 1'b0 : exp_bit(m_pos));
    chk(c_mode == 2'd2 ? "R8" : "R4", "fclk_o", fclk_o, exp_fclk());
    chk("R11", "underrun", underrun, eu);
    chk("R10", "in_ready", in_ready, ql.size() == 0);
    chk("R9", "cfg_err", cfg_err, exp_err());
    chk("R2", "clk_oe", clk_oe, c_master);
    if (!c_master) chk("R2", "bclk_o in slave", bclk_o, 0);
  endtask

  always begin
    @(negedge clk); #1;
    acc_pend = in_valid && in_ready;
    acc_l = in_left; acc_r = in_right;
    bh = {bh[1:0], bclk_i};
    fh = {fh[1:0], fclk_i};
    @(posedge clk); #1;
    if (mon_on) step();
  end

  always @(negedge clk) begin
    if (feed_on) begin
      if (!in_valid || acc_pend) begin
        if (feed_left > 0) begin
          in_valid = 1; in_left = $urandom; in_right = $urandom; feed_left--;
        end else in_valid = 0;
      end
    end else in_valid = 0;
  end

  int s_div = 0, sp = 0;
  always @(negedge clk) begin
    if (slv_on) begin
      s_div++;
      if (s_div == SDIV) begin
        s_div = 0;
        bclk_i = ~bclk_i;
        if (bclk_i == c_edge) begin
          sp = (sp + 1) % n_len();
          fclk_i = (c_mode == 2'd2) ? (sp == 0) : ((sp >= n_len()/2) ^ c_pol);
        end
      end
    end
  end

  task automatic run_case(string t, bit ms, bit r32, bit ed, bit [1:0] wl, bit [1:0] md,
                          bit nd, bit pl, int frames, int npairs);
    @(negedge clk);
    mon_on = 0; feed_on = 0; slv_on = 0; rst_n = 0;
    c_master = ms; c_rate32 = r32; c_edge = ed; c_wlen = wl; c_mode = md;
    c_nodelay = nd; c_pol = pl;
    bclk_i = 0; s_div = 0; sp = n_len() / 2;
    fclk_i = (md == 2'd2) ? 1'b0 : (1'b1 ^ pl);
    repeat (3) @(negedge clk);
    model_reset();
    tag = t; feed_left = npairs;
    rst_n = 1; feed_on = 1; slv_on = !ms; mon_on = 1;
    repeat (frames * n_len() * 2 * (ms ? DIV : SDIV)) @(negedge clk);
    mon_on = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    c_master = 1; c_mode = 2'd3;
    repeat (3) @(negedge clk);
    chk("R1", "clk_oe in reset", clk_oe, 0);
    chk("R1", "cfg_err in reset", cfg_err, 0);
    chk("R1", "in_ready in reset", in_ready, 1);
    chk("R1", "sd_o in reset", sd_o, 0);
    chk("R1", "underrun in reset", underrun, 0);
    chk("R1", "bclk_o in reset", bclk_o, 0);
    rst_n = 1;
    @(posedge clk); #1;
    chk("R1", "clk_oe after reset", clk_oe, 1);
    chk("R1", "cfg_err after reset", cfg_err, 1);

    run_case("R5,R6 i2s 24b",      1, 0, 0, 2'd1, 2'd0, 0, 0, 3, 1000);
    run_case("R3,R6 lj 16b",       1, 0, 1, 2'd3, 2'd0, 1, 1, 3, 1000);
    run_case("R5,R6 i2s 32b wrap", 1, 0, 0, 2'd0, 2'd0, 0, 1, 3, 1000);
    run_case("R2,R6 i2s 20b 32fs", 1, 1, 1, 2'd2, 2'd0, 0, 0, 3, 1000);
    run_case("R7 rj 20b",          1, 0, 0, 2'd2, 2'd1, 1, 0, 3, 1000);
    run_case("R7 rj 24b delay",    1, 0, 1, 2'd1, 2'd1, 0, 1, 3, 1000);
    run_case("R8 pcm a 16b 32fs",  1, 1, 0, 2'd3, 2'd2, 0, 1, 3, 1000);
    run_case("R8 pcm b 32b",       1, 0, 1, 2'd0, 2'd2, 1, 0, 3, 1000);
    run_case("R11 underrun",       1, 0, 0, 2'd3, 2'd0, 0, 0, 5, 2);
    run_case("R9 rj 32fs",         1, 1, 0, 2'd3, 2'd1, 0, 0, 2, 1000);
    run_case("R9 mode3",           1, 0, 0, 2'd3, 2'd3, 0, 0, 2, 1000);
    run_case("R9 24b 32fs",        1, 1, 0, 2'd1, 2'd0, 0, 0, 2, 1000);
    run_case("R9 rj 32b",          1, 0, 0, 2'd0, 2'd1, 0, 0, 2, 1000);
    run_case("R9 pcm 20b 32fs",    1, 1, 0, 2'd2, 2'd2, 0, 0, 2, 1000);
    run_case("R12 slave lj 24b",   0, 0, 0, 2'd1, 2'd0, 1, 1, 3, 1000);
    run_case("R12 slave i2s 16b",  0, 1, 1, 2'd3, 2'd0, 0, 0, 3, 1000);
    run_case("R12 slave pcm 16b",  0, 1, 1, 2'd3, 2'd2, 0, 0, 3, 1000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule